// File: doc/BRIEF.md
# Multi-Mode Capture Timer

A 16-bit down-counting timer with two auxiliary registers, A and B, each paired with an input pin of the same name. A 3-bit mode field selects one of three behaviours. In pulse-width mode the counter runs on the cycle tick and reloads alternately from A and B, optionally inverting an output pin at every reload. In event-counting mode the counter steps down on rising edges seen at pin A. In capture mode the counter runs freely on the cycle tick and a selected edge on either pin copies the count into that pin's register.

A processor reaches the block through a simple register port with a 2-bit select: 0 is the counter, 1 is register A, 2 is register B and 3 is the control word. Control bit 0 is the run switch in the pulse-width and event modes and becomes the underflow pending flag in capture mode. One enable bit gates two sources onto interrupt line A, so firmware reads both pending flags to find the cause. The cycle tick comes from a prescaler outside the block.

Top module: `capture_timer`

## Requirements
- R1: In capture mode the counter decrements by one on every cycle where `cyc_tick` is 1, whatever control bit 0 holds, and wraps from 0x0000 to 0xFFFF.
- R2: In capture mode a selected edge on pin A copies the count held in that cycle into register A and sets pending flag A; a selected edge on pin B does the same for register B and pending flag B.
- R3: The capture modes select edges as follows: 010 is A rising and B falling, 011 is A rising and B rising, 110 is A falling and B falling, 111 is A falling and B rising; an edge of the other polarity changes neither register nor flag.
- R4: Pending flags stay set until software writes 0 to them; an event that sets a flag in the same cycle as a write that clears it leaves the flag set.
- R5: In capture mode every counter underflow sets control bit 0, also when a capture happens in the same cycle.
- R6: `irq_a` is 1 exactly when enable A is set and either pending flag A is set or, in capture mode, control bit 0 is set; `irq_b` is 1 exactly when enable B and pending flag B are both set.
- R7: In modes 100 and 101 with control bit 0 at 1, the counter decrements on each tick; a tick at zero reloads it, from A first after entering the mode and then alternately from B and A, setting pending flag A on an A reload and pending flag B on a B reload.
- R8: Mode 101 inverts `pin_a_out` at every reload; mode 100 leaves it unchanged.
- R9: In modes 000 and 001 with control bit 0 at 1, the counter decrements once per rising edge on pin A and ignores ticks and falling edges; a step from zero wraps to 0xFFFF and sets pending flag A.
- R10: In modes 000 and 001 a rising edge on pin B sets pending flag B.
- R11: In the pulse-width and event modes, control bit 0 at 0 holds the counter.
- R12: Pin inputs pass through a two-flop synchronizer, so a pin change present before clock edge k acts at edge k+2.
- R13: The control word (select 3) holds bit 0 run/underflow, bits 3:1 mode, bit 4 pending A, bit 5 enable A, bit 6 pending B, bit 7 enable B, reads zero above bit 7, and resets, like the counter, both registers and `pin_a_out`, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Cycle-rate count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 register A, 2 register B, 3 control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | 16 | Read data, combinational |
| pin_a_in | input | 1 | Pin A: capture or event input |
| pin_b_in | input | 1 | Pin B: capture or event input |
| pin_a_out | output | 1 | Pin A output, toggled in mode 101 |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
In capture mode a pin-A capture, a counter underflow and a software write that clears the flags can all land on the same clock edge. The bench provokes this by presetting the counter to zero with the tick held low, changing pin A, and then raising the tick and issuing the clearing write exactly on the edge where the synchronised edge arrives. It judges the result by reading register A as 0x0000, the counter as 0xFFFF, and both pending flag A and control bit 0 as set, with `irq_a` high.

// File: rtl/tmr_pkg.sv
// Shared types for the multi-mode capture timer.
// Assumes a control word of eight bits placed at the bottom of the data bus.
package tmr_pkg;

    // Register port select codes.
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_REG_A = 2'd1,
        SEL_REG_B = 2'd2,
        SEL_CTRL  = 2'd3
    } tmr_sel_e;

    // Operating class derived from the 3-bit mode field.
    typedef enum logic [1:0] {
        OP_EVENT   = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_PWM     = 2'd2
    } tmr_op_e;

    // Control word layout, most significant field first.
    typedef struct packed {
        logic       en_b;
        logic       pend_b;
        logic       en_a;
        logic       pend_a;
        logic [2:0] mode;
        logic       bit0;
    } tmr_ctrl_t;

    // Map the mode field onto its operating class.
    function automatic tmr_op_e decode_op(input logic [2:0] m);
        tmr_op_e r;
        case (m[2:1])
            2'b00:   r = OP_EVENT;
            2'b10:   r = OP_PWM;
            default: r = OP_CAPTURE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_pin_edge.sv
// Synchronizes one asynchronous pin and flags its rising and falling edges.
// Assumes the pin is low while reset is held; the flags last one cycle.
module tmr_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] chain;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/tmr_core.sv
// Down counter with mode-dependent stepping, alternating reload and pin toggle.
// Assumes mode, run and reload values come from the register file of the top.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             run,
    input  logic             tick,
    input  logic             ev_clk,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_a,
    input  logic [CNT_W-1:0] reload_b,
    output logic [CNT_W-1:0] count,
    output logic             uf,
    output logic             rl_a,
    output logic             rl_b,
    output logic             pwm_out
);

    tmr_op_e op;
    logic    step;
    logic    phase;

    assign op = decode_op(mode);

    // Choose the step source for the current mode.
    always_comb begin
        case (op)
            OP_PWM:   step = run & tick;
            OP_EVENT: step = run & ev_clk;
            default:  step = tick;
        endcase
    end

    assign uf   = step && (count == '0);
    assign rl_a = uf && (op == OP_PWM) && !phase;
    assign rl_b = uf && (op == OP_PWM) && phase;

    // Counter: software load, reload at zero, else step down with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load_en) count <= load_val;
        else if (rl_a)    count <= reload_a;
        else if (rl_b)    count <= reload_b;
        else if (step)    count <= count - CNT_W'(1);
    end

    // Reload phase: flips at each reload, cleared outside the pulse-width modes.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= 1'b0;
        else if (op != OP_PWM) phase <= 1'b0;
        else if (uf)           phase <= ~phase;
    end

    // Output pin: inverted at each reload when the toggle variant is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pwm_out <= 1'b0;
        else if ((rl_a || rl_b) && mode[0])  pwm_out <= ~pwm_out;
    end

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE && tick && !load_en && count != '0)
        |=> count == $past(count) - CNT_W'(1));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE && uf && !load_en) |=> count == '1);

    p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PWM && uf) |=> phase != $past(phase));

    p_event_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EVENT && !ev_clk && !load_en) |=> $stable(count));

    p_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_CAPTURE && !run && !load_en) |=> $stable(count));

endmodule

// File: rtl/capture_timer.sv
// Multi-mode timer top: register file, pending flags, capture and interrupts.
// Assumes a single clock domain; pins are asynchronous and get synchronized here.
module capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    output logic             pin_a_out,
    output logic             irq_a,
    output logic             irq_b
);

    localparam int CTRL_W = $bits(tmr_ctrl_t);
    localparam int NPINS  = 2;

    tmr_ctrl_t        ctl;
    logic [CNT_W-1:0] reg_a, reg_b, count;
    logic [NPINS-1:0] pins, rises, falls;
    logic             uf, rl_a, rl_b;
    logic             cap_a, cap_b, set_a, set_b, uf_flag;
    logic             ctrl_wr, cnt_wr, a_wr, b_wr;
    tmr_op_e          op;

    assign pins = {pin_b_in, pin_a_in};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .rise (rises[i]),
            .fall (falls[i])
        );
    end

    assign op      = decode_op(ctl.mode);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
    assign a_wr    = wr_en && (wr_sel == SEL_REG_A);
    assign b_wr    = wr_en && (wr_sel == SEL_REG_B);

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (ctl.mode),
        .run     (ctl.bit0),
        .tick    (cyc_tick),
        .ev_clk  (rises[0]),
        .load_en (cnt_wr),
        .load_val(wr_data),
        .reload_a(reg_a),
        .reload_b(reg_b),
        .count   (count),
        .uf      (uf),
        .rl_a    (rl_a),
        .rl_b    (rl_b),
        .pwm_out (pin_a_out)
    );

    // Capture triggers: mode bit 2 picks A's edge, mode bit 0 picks B's edge.
    always_comb begin
        cap_a = (op == OP_CAPTURE) && (ctl.mode[2] ? falls[0] : rises[0]);
        cap_b = (op == OP_CAPTURE) && (ctl.mode[0] ? rises[1] : falls[1]);
    end

    // Hardware flag-set sources per mode.
    always_comb begin
        case (op)
            OP_PWM:   begin set_a = rl_a; set_b = rl_b;     end
            OP_EVENT: begin set_a = uf;   set_b = rises[1]; end
            default:  begin set_a = cap_a; set_b = cap_b;   end
        endcase
        uf_flag = (op == OP_CAPTURE) && uf;
    end

    // Control word: software write first, hardware sets override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (ctrl_wr) ctl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (set_a)   ctl.pend_a <= 1'b1;
            if (set_b)   ctl.pend_b <= 1'b1;
            if (uf_flag) ctl.bit0   <= 1'b1;
        end
    end

    // Register A: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_a <= '0;
        else if (cap_a) reg_a <= count;
        else if (a_wr)  reg_a <= wr_data;
    end

    // Register B: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_b <= '0;
        else if (cap_b) reg_b <= count;
        else if (b_wr)  reg_b <= wr_data;
    end

    // Interrupt lines: enable A covers capture A and the capture-mode underflow.
    assign irq_a = ctl.en_a & (ctl.pend_a | ((op == OP_CAPTURE) & ctl.bit0));
    assign irq_b = ctl.en_b & ctl.pend_b;

    // Read multiplexer.
    always_comb begin
        case (tmr_sel_e'(rd_sel))
            SEL_COUNT: rd_data = count;
            SEL_REG_A: rd_data = reg_a;
            SEL_REG_B: rd_data = reg_b;
            default:   rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctl};
        endcase
    end

    p_cap_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> reg_a == $past(count));

    p_cap_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_b |=> reg_b == $past(count));

    p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pend_a && !ctrl_wr) |=> ctl.pend_a);

    p_uf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE && uf) |=> ctl.bit0);

    p_evt_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EVENT && rises[1]) |=> ctl.pend_b);

endmodule

// File: tb/capture_timer_test.sv
// Directed bench for the multi-mode capture timer; one task per scenario.
module capture_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        pin_a_in = 1'b0;
    logic        pin_b_in = 1'b0;
    logic        pin_a_out, irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    capture_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_tick (cyc_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .pin_a_in (pin_a_in),
        .pin_b_in (pin_b_in),
        .pin_a_out(pin_a_out),
        .irq_a    (irq_a),
        .irq_b    (irq_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [1:0] sel, input logic [15:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a();
        pin_a_in = 1'b1; wait_n(2);
        pin_a_in = 1'b0; wait_n(4);
    endtask

    task automatic t_reset();
        check_reg("R13 count", 2'd0, 16'h0000);
        check_reg("R13 ctrl", 2'd3, 16'h0000);
        check_reg("R13 regA", 2'd1, 16'h0000);
        check("R13 pin_a_out", {15'd0, pin_a_out}, 16'd0);
        check("R6 irq idle", {14'd0, irq_a, irq_b}, 16'd0);
    endtask

    // Mode 011: A rising, B rising.
    task automatic t_capture_rise();
        wr(2'd3, 16'h00A6);
        wr(2'd0, 16'h1234);
        pin_a_in = 1'b1; wait_n(4);
        check_reg("R2 regA", 2'd1, 16'h1234);
        check_reg("R2 pendA", 2'd3, 16'h00B6);
        check("R6 irq_a", {15'd0, irq_a}, 16'd1);
        check("R6 irq_b low", {15'd0, irq_b}, 16'd0);
        wr(2'd0, 16'h0042);
        pin_b_in = 1'b1; wait_n(4);
        check_reg("R2 regB", 2'd2, 16'h0042);
        check_reg("R2 pendB", 2'd3, 16'h00F6);
        check("R6 irq_b", {15'd0, irq_b}, 16'd1);
        wr(2'd3, 16'h00A6);
        check_reg("R4 cleared", 2'd3, 16'h00A6);
        check("R6 irq cleared", {14'd0, irq_a, irq_b}, 16'd0);
        wr(2'd0, 16'h5555);
        pin_a_in = 1'b0; wait_n(4);
        check_reg("R3 wrong edge regA", 2'd1, 16'h1234);
        check_reg("R3 wrong edge flag", 2'd3, 16'h00A6);
    endtask

    // Mode 110: A falling, B falling.
    task automatic t_capture_fall();
        wr(2'd3, 16'h00AC);
        wr(2'd0, 16'h0777);
        pin_a_in = 1'b1; wait_n(4);
        check_reg("R3 rise ignored", 2'd3, 16'h00AC);
        pin_a_in = 1'b0; wait_n(4);
        check_reg("R3 fall regA", 2'd1, 16'h0777);
        check_reg("R3 fall pendA", 2'd3, 16'h00BC);
        wr(2'd0, 16'h0888);
        pin_b_in = 1'b0; wait_n(4);
        check_reg("R3 fall regB", 2'd2, 16'h0888);
        check_reg("R3 fall pendB", 2'd3, 16'h00FC);
        wr(2'd3, 16'h00AC);
    endtask

    // Free running in capture mode with bit 0 clear, then wrap.
    task automatic t_free_run();
        wr(2'd0, 16'h0005);
        cyc_tick = 1'b1; wait_n(3); cyc_tick = 1'b0;
        check_reg("R1 decrement", 2'd0, 16'h0002);
        cyc_tick = 1'b1; wait_n(3); cyc_tick = 1'b0;
        check_reg("R1 wrap", 2'd0, 16'hFFFF);
        check_reg("R5 uf flag", 2'd3, 16'h00AD);
        check("R6 irq_a from uf", {15'd0, irq_a}, 16'd1);
        wr(2'd3, 16'h008D);
        check("R6 enable A gates uf", {15'd0, irq_a}, 16'd0);
        wr(2'd3, 16'h00AC);
    endtask

    // Capture, underflow and clearing write on one edge.
    task automatic t_coincide();
        pin_a_in = 1'b1; wait_n(4);
        wr(2'd0, 16'h0000);
        pin_a_in = 1'b0;
        wait_n(2);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h00AC; cyc_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cyc_tick = 1'b0;
        check_reg("R12 R2 regA at edge", 2'd1, 16'h0000);
        check_reg("R1 count wrapped", 2'd0, 16'hFFFF);
        check_reg("R4 R5 flags survive clear", 2'd3, 16'h00BD);
        check("R6 irq_a", {15'd0, irq_a}, 16'd1);
        wr(2'd3, 16'h00AC);
        check_reg("R4 plain clear", 2'd3, 16'h00AC);
    endtask

    // Event counting on pin A, pin B flag, stop.
    task automatic t_event();
        cyc_tick = 1'b1;
        wr(2'd3, 16'h00A1);
        wr(2'd0, 16'h0002);
        pulse_a(); pulse_a();
        check_reg("R9 two edges", 2'd0, 16'h0000);
        check_reg("R9 no flag yet", 2'd3, 16'h00A1);
        pulse_a();
        check_reg("R9 wrap", 2'd0, 16'hFFFF);
        check_reg("R9 pendA", 2'd3, 16'h00B1);
        pin_b_in = 1'b1; wait_n(4);
        check_reg("R10 pendB", 2'd3, 16'h00F1);
        check("R10 irq_b", {15'd0, irq_b}, 16'd1);
        pin_b_in = 1'b0; wait_n(4);
        wr(2'd3, 16'h00A0);
        pulse_a();
        check_reg("R11 event stopped", 2'd0, 16'hFFFF);
    endtask

    // Pulse-width modes with alternating reload.
    task automatic t_pwm();
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h00AB);
        wait_n(1);
        check_reg("R7 reload A", 2'd0, 16'h0003);
        check("R8 toggle 1", {15'd0, pin_a_out}, 16'd1);
        check_reg("R7 pendA", 2'd3, 16'h00BB);
        wait_n(4);
        check_reg("R7 reload B", 2'd0, 16'h0001);
        check("R8 toggle 2", {15'd0, pin_a_out}, 16'd0);
        check_reg("R7 pendB", 2'd3, 16'h00FB);
        wait_n(2);
        check_reg("R7 reload A again", 2'd0, 16'h0003);
        check("R8 toggle 3", {15'd0, pin_a_out}, 16'd1);
        wr(2'd3, 16'h00A9);
        wait_n(5);
        check_reg("R7 mode 100 reloads", 2'd0, 16'h0003);
        check_reg("R7 mode 100 flags", 2'd3, 16'h00F9);
        check("R8 no toggle", {15'd0, pin_a_out}, 16'd1);
        wr(2'd3, 16'h00A8);
        wait_n(5);
        check_reg("R11 pwm stopped", 2'd0, 16'h0002);
        cyc_tick = 1'b0;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_rise();
        t_capture_fall();
        t_free_run();
        t_coincide();
        t_event();
        t_pwm();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule